// File: doc/BRIEF.md
# Clock Buffer Power Sequencer and Output Gate

This block controls when the outputs of a multi-output differential clock buffer run. One asynchronous input carries both power-good and power-down: high means the supply is good and the part may run, low means power-down. The input passes through a two-flop synchronizer, and a rising-edge detector follows it. The first rising edge after reset captures two configuration straps. One is the frequency select. The other is a bandwidth/bypass select that arrives already decoded from a three-level pin. Both straps are then held until the next reset. Every later rising edge only takes the part out of power-down and leaves the held straps as they are.

Each time power-down is released, a counter runs for a parameterised number of ticks before any output starts. If power-down returns while the counter runs, the count is cancelled. In the running state each output follows its own software enable bit. The feedback pair runs whatever the enable bits say. In power-down every output and the feedback pair are stopped, which means driven low/low. A gate changes only while its reference clock is in its low phase, so no runt pulse reaches a gated output. Each output is modelled as a single run bit.

Top module: `clkbuf_pwr_ctrl`

## Requirements
- R1: During and after reset, every `out_run` bit, `fb_run`, `straps_held`, `freq_sel` and `bw_mode` are 0.
- R2: On the first synchronized rising edge of `pwr_good` after reset, `strap_freq` and the decoded `strap_bw_lvl` are captured into `freq_sel` and `bw_mode`, and `straps_held` goes to 1.
- R3: Later rising edges of `pwr_good` do not change `freq_sel` or `bw_mode`, even when the strap inputs have changed.
- R4: While `pwr_good` is low, every `out_run` bit and `fb_run` are forced to 0, whatever `out_en` holds.
- R5: While running, `out_run[i]` equals `out_en[i]`, and `fb_run` is 1 whatever the enable bits are.
- R6: With `ref_lvl` low, `fb_run` first rises exactly DELAY+4 clock cycles after `pwr_good` is raised. That is two synchronizer flops, one edge-detect cycle, DELAY count cycles and one gate register. It is still 0 one cycle earlier.
- R7: If `pwr_good` falls before the delay expires, no output starts. The next rise restarts the full delay.
- R8: An `out_run` or `fb_run` bit changes value only on a clock edge where `ref_lvl` was 0 in the previous cycle. While `ref_lvl` is 1, all gates keep their state.
- R9: The `strap_bw_lvl` codes 00 (low), 01 (mid) and 10 (high) map to `bw_mode` values 00 (low-bandwidth PLL), 01 (bypass, PLL off) and 11 (high-bandwidth PLL). The unused code 11 maps to 01 (bypass).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Asynchronous power-good (high) / power-down (low) |
| strap_freq | input | 1 | Frequency-select strap level |
| strap_bw_lvl | input | 2 | Decoded tri-level bandwidth strap: 00 low, 01 mid, 10 high |
| ref_lvl | input | 1 | Sampled level of the reference clock; gates change only while it is 0 |
| out_en | input | N_OUT | Per-output enable bits from the management bus |
| out_run | output | N_OUT | Per-output run bit (0 = low/low) |
| fb_run | output | 1 | Feedback pair run bit |
| straps_held | output | 1 | Straps have been captured |
| freq_sel | output | 1 | Held frequency select |
| bw_mode | output | 2 | Held bandwidth mode code |

## Verification
The hardest case to reach from the ports is a second rising edge of power-good that arrives after the strap pins have changed. Only that case shows whether the latch is really one-shot. The bench therefore powers up once and then powers down. It then drives different strap values and raises power-good again, and it checks that the held values did not move. The cancelled delay is reached by dropping power-good a few cycles into the count. A run bit that is ready but held off by a high reference phase is reached by holding `ref_lvl` high across the point where the count expires.

// File: rtl/clkbuf_pwr_pkg.sv
package clkbuf_pwr_pkg;

    typedef enum logic [1:0] {
        BW_LOW    = 2'b00,
        BW_BYPASS = 2'b01,
        BW_HIGH   = 2'b11
    } bw_mode_e;

    typedef enum logic [1:0] {
        SEQ_OFF  = 2'b00,
        SEQ_WAIT = 2'b01,
        SEQ_RUN  = 2'b10
    } seq_state_e;

    typedef struct packed {
        logic     freq;
        bw_mode_e bw;
    } strap_t;

    function automatic bw_mode_e decode_bw(input logic [1:0] lvl);
        case (lvl)
            2'b00:   return BW_LOW;
            2'b10:   return BW_HIGH;
            default: return BW_BYPASS;
        endcase
    endfunction

endpackage

// File: rtl/pg_sync.sv
module pg_sync (
    input  logic clk,
    input  logic rst,
    input  logic pg_async,
    output logic pg_s,
    output logic pg_rise
);
    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= pg_async;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign pg_s    = sync_q;
    assign pg_rise = sync_q & ~last_q;
endmodule

// File: rtl/strap_latch.sv
module strap_latch
    import clkbuf_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pg_rise,
    input  logic       freq_in,
    input  logic [1:0] bw_lvl_in,
    output strap_t     straps,
    output logic       held
);
    strap_t straps_q;
    logic   held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            straps_q <= '{freq: 1'b0, bw: BW_LOW};
            held_q   <= 1'b0;
        end else if (pg_rise && !held_q) begin
            straps_q <= '{freq: freq_in, bw: decode_bw(bw_lvl_in)};
            held_q   <= 1'b1;
        end
    end

    assign straps = straps_q;
    assign held   = held_q;

    // R3
    straps_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (held_q && $past(held_q)) |-> $stable(straps_q));

    // R2
    held_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(held_q) |-> held_q);
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
    import clkbuf_pwr_pkg::*;
#(
    parameter int DELAY = 37500
) (
    input  logic clk,
    input  logic rst,
    input  logic pg_s,
    input  logic pg_rise,
    output logic running
);
    localparam int CW = $clog2(DELAY + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

    seq_state_e state_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_OFF;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SEQ_OFF: begin
                    cnt_q <= '0;
                    if (pg_rise) state_q <= SEQ_WAIT;
                end
                SEQ_WAIT: begin
                    if (!pg_s) begin
                        state_q <= SEQ_OFF;
                        cnt_q   <= '0;
                    end else if (cnt_q == LAST) begin
                        state_q <= SEQ_RUN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SEQ_RUN: begin
                    if (!pg_s) state_q <= SEQ_OFF;
                end
                default: state_q <= SEQ_OFF;
            endcase
        end
    end

    assign running = (state_q == SEQ_RUN);

    // R6
    run_after_count_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> ($past(state_q) == SEQ_WAIT && $past(cnt_q) == LAST));

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
endmodule

// File: rtl/out_gate.sv
module out_gate #(
    parameter int N_OUT = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             running,
    input  logic             ref_lvl,
    input  logic [N_OUT-1:0] en,
    output logic [N_OUT-1:0] run_q,
    output logic             fb_q
);
    for (genvar i = 0; i < N_OUT; i++) begin : g_pair
        logic gate_q;
        always_ff @(posedge clk) begin
            if (rst)           gate_q <= 1'b0;
            else if (!ref_lvl) gate_q <= running & en[i];
        end
        assign run_q[i] = gate_q;
    end

    logic fb_gate_q;
    always_ff @(posedge clk) begin
        if (rst)           fb_gate_q <= 1'b0;
        else if (!ref_lvl) fb_gate_q <= running;
    end
    assign fb_q = fb_gate_q;

    // R8
    gate_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
        ({run_q, fb_q} != $past({run_q, fb_q})) |-> !$past(ref_lvl));

    // R5
    fb_covers_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        (|run_q) |-> fb_q);
endmodule

// File: rtl/clkbuf_pwr_ctrl.sv
module clkbuf_pwr_ctrl
    import clkbuf_pwr_pkg::*;
#(
    parameter int N_OUT = 15,
    parameter int DELAY = 37500
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_good,
    input  logic             strap_freq,
    input  logic [1:0]       strap_bw_lvl,
    input  logic             ref_lvl,
    input  logic [N_OUT-1:0] out_en,
    output logic [N_OUT-1:0] out_run,
    output logic             fb_run,
    output logic             straps_held,
    output logic             freq_sel,
    output logic [1:0]       bw_mode
);
    logic   pg_s, pg_rise, running;
    strap_t straps;

    pg_sync u_sync (
        .clk(clk), .rst(rst), .pg_async(pwr_good),
        .pg_s(pg_s), .pg_rise(pg_rise)
    );

    strap_latch u_strap (
        .clk(clk), .rst(rst), .pg_rise(pg_rise),
        .freq_in(strap_freq), .bw_lvl_in(strap_bw_lvl),
        .straps(straps), .held(straps_held)
    );

    pwr_seq #(.DELAY(DELAY)) u_seq (
        .clk(clk), .rst(rst), .pg_s(pg_s), .pg_rise(pg_rise),
        .running(running)
    );

    out_gate #(.N_OUT(N_OUT)) u_gate (
        .clk(clk), .rst(rst), .running(running), .ref_lvl(ref_lvl),
        .en(out_en), .run_q(out_run), .fb_q(fb_run)
    );

    assign freq_sel = straps.freq;
    assign bw_mode  = straps.bw;

    // R4
    pd_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fb_run) |-> $past(pg_s));
endmodule

// File: tb/tb_clkbuf_pwr_ctrl.sv
module tb_clkbuf_pwr_ctrl;
    localparam int N = 4;
    localparam int D = 12;

    logic clk = 0, rst = 1, pwr_good = 0, strap_freq = 0, ref_lvl = 0;
    logic [1:0] strap_bw_lvl = 0;
    logic [N-1:0] out_en = '1;
    logic [N-1:0] out_run;
    logic fb_run, straps_held, freq_sel;
    logic [1:0] bw_mode;

    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    clkbuf_pwr_ctrl #(.N_OUT(N), .DELAY(D)) dut (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .strap_freq(strap_freq),
        .strap_bw_lvl(strap_bw_lvl), .ref_lvl(ref_lvl), .out_en(out_en),
        .out_run(out_run), .fb_run(fb_run), .straps_held(straps_held),
        .freq_sel(freq_sel), .bw_mode(bw_mode)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; pwr_good = 0; ref_lvl = 0; out_en = '1;
        cyc(3);
        rst = 0;
        @(negedge clk);
    endtask

    // raise pwr_good at a negedge, count edges until fb_run is seen high
    task automatic raise_and_count(output int n);
        n = 0;
        pwr_good = 1;
        for (int i = 0; i < 4 * D; i++) begin
            @(negedge clk);
            n++;
            if (fb_run) break;
        end
    endtask

    task automatic t_reset();
        do_reset();
        // R1
        chk(out_run == 0 && !fb_run, "R1 outputs", {out_run, fb_run}, 0);
        chk(!straps_held && !freq_sel && bw_mode == 0, "R1 straps",
            {straps_held, freq_sel, bw_mode}, 0);
    endtask

    task automatic t_first_up();
        int n;
        do_reset();
        strap_freq = 1; strap_bw_lvl = 2'b10;
        raise_and_count(n);
        // R6
        chk(n == D + 4, "R6 delay", n, D + 4);
        // R2 / R9
        chk(straps_held && freq_sel, "R2 capture", {straps_held, freq_sel}, 3);
        chk(bw_mode == 2'b11, "R9 high", bw_mode, 3);
        // R5
        chk(out_run == '1, "R5 all enabled", out_run, (1 << N) - 1);
    endtask

    task automatic t_delay_edge();
        do_reset();
        pwr_good = 1;
        cyc(D + 3);
        // R6: one cycle before start
        chk(!fb_run, "R6 early", fb_run, 0);
        cyc(1);
        chk(fb_run, "R6 on time", fb_run, 1);
    endtask

    task automatic t_enable_mask();
        out_en = 4'b0101;
        cyc(1);
        // R5
        chk(out_run == 4'b0101, "R5 mask", out_run, 5);
        chk(fb_run, "R5 fb", fb_run, 1);
        out_en = 4'b0000;
        cyc(1);
        chk(out_run == 0 && fb_run, "R5 none", {out_run, fb_run}, 1);
        out_en = '1;
        cyc(1);
    endtask

    task automatic t_pd_and_reassert();
        int n;
        pwr_good = 0;
        cyc(6);
        // R4
        chk(out_run == 0 && !fb_run, "R4 powerdown", {out_run, fb_run}, 0);
        out_en = '1;
        cyc(3);
        chk(out_run == 0, "R4 enables ignored", out_run, 0);
        strap_freq = 0; strap_bw_lvl = 2'b00;
        raise_and_count(n);
        // R3
        chk(freq_sel == 1 && bw_mode == 2'b11, "R3 no resample",
            {freq_sel, bw_mode}, 7);
        chk(n == D + 4, "R6 second up", n, D + 4);
    endtask

    task automatic t_cancel();
        int n;
        do_reset();
        pwr_good = 1;
        cyc(6);
        pwr_good = 0;
        cyc(2 * D);
        // R7
        chk(!fb_run && out_run == 0, "R7 cancelled", {out_run, fb_run}, 0);
        raise_and_count(n);
        chk(n == D + 4, "R7 restart", n, D + 4);
    endtask

    task automatic t_ref_phase();
        do_reset();
        ref_lvl = 1;
        pwr_good = 1;
        cyc(D + 8);
        // R8
        chk(!fb_run && out_run == 0, "R8 held off", {out_run, fb_run}, 0);
        ref_lvl = 0;
        cyc(1);
        chk(fb_run && out_run == '1, "R8 low phase start", {out_run, fb_run}, 31);
        ref_lvl = 1;
        pwr_good = 0;
        cyc(8);
        chk(fb_run, "R8 stop held", fb_run, 1);
        ref_lvl = 0;
        cyc(1);
        chk(!fb_run, "R8 low phase stop", fb_run, 0);
    endtask

    task automatic t_decode();
        logic [1:0] exp_tab [4];
        exp_tab[0] = 2'b00; exp_tab[1] = 2'b01; exp_tab[2] = 2'b11; exp_tab[3] = 2'b01;
        for (int c = 0; c < 4; c++) begin
            do_reset();
            strap_freq = 0;
            strap_bw_lvl = 2'(c);
            pwr_good = 1;
            cyc(5);
            // R9
            chk(bw_mode == exp_tab[c] && !freq_sel, "R9 decode", bw_mode, exp_tab[c]);
        end
    endtask

    initial begin
        t_reset();
        t_first_up();
        t_delay_edge();
        t_enable_mask();
        t_pd_and_reassert();
        t_cancel();
        t_ref_phase();
        t_decode();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule